// File: doc/BRIEF.md
# Iterative 64-bit Multiplier with Low, High and Word Results

This unit sits in the execute stage of a 64-bit integer pipeline and multiplies two register operands. A 3-bit operation code selects one of three results. The first is the low 64 bits of the product. The second is the high 64 bits of the full 128-bit product, with the operands read as signed×signed, signed×unsigned or unsigned×unsigned. The third is a word result, in which only the low 32 bits of each operand are multiplied and the 32-bit product is sign-extended to 64 bits. The low half of a product does not depend on how the operands are interpreted, so one low operation covers signed and unsigned use.

Requests use a valid/ready handshake. Internally, each operand is widened by one bit, with sign or zero extension chosen by the operation. The multiplier operand is then consumed in `STEPS` equal chunks, one per cycle. A single narrow partial product is added into a double-width accumulator each cycle. The response register keeps its value with valid high until the consumer takes it, and no new request is accepted while a request is in flight or a response is pending.

Top module: `mulhl_unit`

## Requirements
- R1: Operation code 0 returns bits [63:0] of req_a × req_b.
- R2: Operation code 1 returns bits [127:64] of the product with both operands read as two's-complement signed.
- R3: Operation code 2 returns bits [127:64] of the product with req_a read as signed and req_b read as unsigned (zero-extended).
- R4: Operation code 3 returns bits [127:64] of the product with both operands read as unsigned.
- R5: Operation code 4 multiplies req_a[31:0] by req_b[31:0] and returns the low 32 bits of that product, sign-extended from bit 31 to 64 bits. Operand bits [63:32] have no effect.
- R6: A request is taken only on a clock edge where req_valid and req_ready are both high. req_ready is low while an operation is in flight or a response is pending, and req_valid asserted in that time has no effect on the result or on later responses.
- R7: rsp_valid rises exactly STEPS (default 3) clock edges after the edge that accepts a request.
- R8: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and rsp_data stays unchanged. The edge with rsp_valid and rsp_ready both high consumes the response: rsp_valid drops and req_ready returns high.
- R9: Synchronous active-high reset drops rsp_valid, raises req_ready and abandons any in-flight operation, so no response appears afterwards.
- R10: Unused operation codes 5, 6 and 7 return the low 64-bit product, as code 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_op | input | 3 | Operation code (0 low, 1 high s×s, 2 high s×u, 3 high u×u, 4 word) |
| req_a | input | 64 | First operand (multiplicand) |
| req_b | input | 64 | Second operand (multiplier) |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result this cycle |
| rsp_data | output | 64 | Selected 64-bit result |

## Verification
The assertions assume that rsp_ready, req_valid and rst always carry known levels. They also assume that a request can be held off for any number of cycles and that rsp_ready can stay low for any number of cycles. The latency check counts edges from acceptance and relies on reset being the only event that abandons an operation. The stimulus changes inputs only on falling edges and never leaves any of them undriven. It sweeps every operation over a grid of boundary operands: the most negative and most positive values, all ones, values with garbage in the upper word, and values that straddle the 32-bit boundary. It also stalls the consumer, asserts req_valid while the unit is busy, and resets in the middle of an operation.

// File: rtl/mulhl_pkg.sv
package mulhl_pkg;

    typedef enum logic [2:0] {
        OP_LO  = 3'd0,
        OP_HSS = 3'd1,
        OP_HSU = 3'd2,
        OP_HUU = 3'd3,
        OP_WLO = 3'd4
    } mul_op_e;

    localparam int WORD_W = 32;

endpackage

// File: rtl/mulhl_opnd_prep.sv
module mulhl_opnd_prep
    import mulhl_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int OPW  = XLEN + 1
) (
    input  logic [2:0]      op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [OPW-1:0]  a_x,
    output logic [OPW-1:0]  b_x
);

    localparam int PADW = OPW - WORD_W;

    always_comb begin
        a_x = {1'b0, a};
        b_x = {1'b0, b};
        case (op)
            OP_HSS: begin
                a_x = {a[XLEN-1], a};
                b_x = {b[XLEN-1], b};
            end
            OP_HSU: begin
                a_x = {a[XLEN-1], a};
                b_x = {1'b0, b};
            end
            OP_WLO: begin
                a_x = {{PADW{1'b0}}, a[WORD_W-1:0]};
                b_x = {{PADW{1'b0}}, b[WORD_W-1:0]};
            end
            default: begin
                a_x = {1'b0, a};
                b_x = {1'b0, b};
            end
        endcase
    end

endmodule

// File: rtl/mulhl_step.sv
module mulhl_step #(
    parameter int OPW   = 65,
    parameter int CW    = 22,
    parameter int ACCW  = 130,
    parameter int STEPS = 3,
    parameter int IDXW  = 2
) (
    input  logic [ACCW-1:0] acc,
    input  logic [OPW-1:0]  a_x,
    input  logic [CW-1:0]   chunk,
    input  logic [IDXW-1:0] idx,
    output logic [ACCW-1:0] acc_nx
);

    logic [ACCW-1:0] a_w;
    logic [ACCW-1:0] c_w;
    logic [ACCW-1:0] prod;
    logic            top_chunk;
    int              shamt;

    always_comb begin
        top_chunk = (int'(idx) == STEPS - 1);
        a_w       = ACCW'($signed(a_x));
        c_w       = top_chunk ? ACCW'($signed(chunk)) : ACCW'(chunk);
        prod      = a_w * c_w;
        shamt     = int'(idx) * CW;
        acc_nx    = acc + (prod << shamt);
    end

endmodule

// File: rtl/mulhl_res_sel.sv
module mulhl_res_sel
    import mulhl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]        op,
    input  logic [2*XLEN-1:0] prod,
    output logic [XLEN-1:0]   res
);

    always_comb begin
        case (op)
            OP_HSS, OP_HSU, OP_HUU: res = prod[2*XLEN-1:XLEN];
            OP_WLO:                 res = XLEN'($signed(prod[WORD_W-1:0]));
            default:                res = prod[XLEN-1:0];
        endcase
    end

endmodule

// File: rtl/mulhl_unit.sv
module mulhl_unit
    import mulhl_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int STEPS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [2:0]      req_op,
    input  logic [XLEN-1:0] req_a,
    input  logic [XLEN-1:0] req_b,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [XLEN-1:0] rsp_data
);

    localparam int OPW  = XLEN + 1;
    localparam int CW   = (OPW + STEPS - 1) / STEPS;
    localparam int BW   = CW * STEPS;
    localparam int ACCW = 2 * OPW;
    localparam int CNTW = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic            busy;
        logic            done;
        logic [CNTW-1:0] step;
        logic [2:0]      op;
        logic [OPW-1:0]  a;
        logic [BW-1:0]   b;
        logic [ACCW-1:0] acc;
        logic [XLEN-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [OPW-1:0]  a_x, b_x;
    logic [ACCW-1:0] acc_nx;
    logic [CW-1:0]   chunk;
    logic [XLEN-1:0] res_nx;

    mulhl_opnd_prep #(.XLEN(XLEN), .OPW(OPW)) u_prep (
        .op  (req_op),
        .a   (req_a),
        .b   (req_b),
        .a_x (a_x),
        .b_x (b_x)
    );

    assign chunk = st_q.b[int'(st_q.step)*CW +: CW];

    mulhl_step #(
        .OPW(OPW), .CW(CW), .ACCW(ACCW), .STEPS(STEPS), .IDXW(CNTW)
    ) u_step (
        .acc    (st_q.acc),
        .a_x    (st_q.a),
        .chunk  (chunk),
        .idx    (st_q.step),
        .acc_nx (acc_nx)
    );

    mulhl_res_sel #(.XLEN(XLEN)) u_sel (
        .op   (st_q.op),
        .prod (acc_nx[2*XLEN-1:0]),
        .res  (res_nx)
    );

    assign req_ready = !st_q.busy && !st_q.done;
    assign rsp_valid = st_q.done;
    assign rsp_data  = st_q.res;

    always_comb begin
        st_d = st_q;
        if (req_valid && req_ready) begin
            st_d.busy = 1'b1;
            st_d.step = '0;
            st_d.op   = req_op;
            st_d.a    = a_x;
            st_d.b    = BW'($signed(b_x));
            st_d.acc  = '0;
        end
        if (st_q.busy) begin
            st_d.acc = acc_nx;
            if (st_q.step == CNTW'(STEPS - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = res_nx;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
        if (st_q.done && rsp_ready) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // Edge counter since acceptance, used only by the latency check
    logic [CNTW+1:0] since_acc_q;
    always_ff @(posedge clk) begin
        if (rst)
            since_acc_q <= '0;
        else if (req_valid && req_ready)
            since_acc_q <= 1;
        else if (rsp_valid && rsp_ready)
            since_acc_q <= '0;
        else if (since_acc_q != 0 && since_acc_q < (CNTW+2)'(STEPS + 1))
            since_acc_q <= since_acc_q + 1'b1;
    end

    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        $rose(rsp_valid) |-> since_acc_q == (CNTW+2)'(STEPS + 1))
        else $error("R7 latency");

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data))
        else $error("R8 hold");

    a_r6_no_accept_pending: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready)
        else $error("R6 ready while pending");

    a_r5_word_sext: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && st_q.op == OP_WLO |->
            rsp_data[XLEN-1:WORD_W] == {(XLEN-WORD_W){rsp_data[WORD_W-1]}})
        else $error("R5 sign extension");

    a_r9_reset: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid && req_ready)
        else $error("R9 reset");

endmodule

// File: tb/mulhl_unit_tb.sv
`timescale 1ns/1ps
module mulhl_unit_tb;

    localparam int STEPS = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = 3'd0;
    logic [63:0] req_a = '0;
    logic [63:0] req_b = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mulhl_unit #(.XLEN(64), .STEPS(STEPS)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_a(req_a), .req_b(req_b),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pick(input int i);
        case (i)
            0: return 64'h0;
            1: return 64'h1;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return 64'h7FFF_FFFF_FFFF_FFFF;
            4: return 64'h8000_0000_0000_0000;
            5: return 64'hDEAD_BEEF_F00D_CAFE;
            6: return 64'h0000_0000_8000_0000;
            7: return 64'hFFFF_FFFF_7FFF_FFFF;
            8: return 64'h1234_5678_9ABC_DEF0;
            default: return 64'h0000_0001_0000_0003;
        endcase
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
        logic [127:0] ss, su, uu;
        logic [63:0]  w;
        ss = {{64{a[63]}}, a} * {{64{b[63]}}, b};
        su = {{64{a[63]}}, a} * {64'h0, b};
        uu = {64'h0, a} * {64'h0, b};
        w  = {32'h0, a[31:0]} * {32'h0, b[31:0]};
        case (op)
            3'd1: return ss[127:64];
            3'd2: return su[127:64];
            3'd3: return uu[127:64];
            3'd4: return {{32{w[31]}}, w[31:0]};
            default: return uu[63:0];
        endcase
    endfunction

    function automatic string tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic run_op(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
                          input bit hold, input bit intrude);
        logic [63:0] exp;
        exp = model(op, a, b);
        @(negedge clk);
        req_op = op; req_a = a; req_b = b; req_valid = 1'b1;
        chk(req_ready === 1'b1, "R6 ready before request", {63'h0, req_ready}, 64'h1);
        @(posedge clk);
        for (int k = 0; k < STEPS; k++) begin
            @(negedge clk);
            if (intrude) begin
                req_valid = 1'b1; req_op = 3'd0; req_a = '1; req_b = 64'h5;
                chk(req_ready === 1'b0, "R6 busy not ready", {63'h0, req_ready}, 64'h0);
            end else begin
                req_valid = 1'b0;
            end
            chk(rsp_valid === 1'b0, "R7 early response", {63'h0, rsp_valid}, 64'h0);
        end
        @(negedge clk);
        chk(rsp_valid === 1'b1, "R7 response on time", {63'h0, rsp_valid}, 64'h1);
        chk(rsp_data === exp, tag(op), rsp_data, exp);
        if (hold) begin
            for (int h = 0; h < 2; h++) begin
                @(negedge clk);
                chk(rsp_valid === 1'b1 && rsp_data === exp, "R8 held", rsp_data, exp);
                chk(req_ready === 1'b0, "R6 pending not ready", {63'h0, req_ready}, 64'h0);
            end
        end
        rsp_ready = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(rsp_valid === 1'b0, "R8 consumed", {63'h0, rsp_valid}, 64'h0);
        chk(req_ready === 1'b1, "R8 ready after consume", {63'h0, req_ready}, 64'h1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid === 1'b0, "R9 reset valid", {63'h0, rsp_valid}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 reset ready", {63'h0, req_ready}, 64'h1);

        // Sweep every operation over the boundary operand grid (R1..R5)
        for (int op = 0; op < 5; op++)
            for (int i = 0; i < 10; i++)
                for (int j = 0; j < 10; j++)
                    run_op(3'(op), pick(i), pick(j), ((i + j) % 7) == 0, 1'b0);

        // R10: unused codes behave as the low product
        for (int op = 5; op < 8; op++)
            for (int i = 2; i < 6; i++)
                run_op(3'(op), pick(i), pick(9 - i), 1'b0, 1'b0);

        // R6: requests raised while busy are ignored
        run_op(3'd1, pick(4), pick(2), 1'b1, 1'b1);
        run_op(3'd2, pick(5), pick(7), 1'b0, 1'b1);
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R6 no extra response", {63'h0, rsp_valid}, 64'h0);

        // R9: reset in the middle of an operation
        @(negedge clk);
        req_op = 3'd0; req_a = 64'h3; req_b = 64'h7; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(rsp_valid === 1'b0, "R9 abort valid", {63'h0, rsp_valid}, 64'h0);
        chk(req_ready === 1'b1, "R9 abort ready", {63'h0, req_ready}, 64'h1);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(rsp_valid === 1'b0, "R9 no stale response", {63'h0, rsp_valid}, 64'h0);
        end
        run_op(3'd3, pick(2), pick(2), 1'b0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule